// File: doc/BRIEF.md
# Periodic Down-Counting Interrupt Timer

This block is a 32-bit timer that counts down on prescaled ticks and raises an interrupt flag each time the count passes through zero. Software programs it through a small word-addressed register port. That port carries a control word, a status word, a load value, a compare value and a live count readback. The block drives one level-sensitive interrupt line.

Two tick-enable inputs come from outside: a fast main tick and a slow 32 kHz tick. Each is a single-cycle pulse in the bus clock domain. The control word picks one of them or none, and a 12-bit prescaler divides the chosen tick. At zero the counter either reloads from the load register, which gives a periodic interrupt, or wraps to all ones. A separate control bit decides whether a write to the load register also replaces the running count at once. Reads are combinational and have no side effects. Writes take effect at the next clock edge.

Top module: `ptmr_top`

## Requirements
- R1: After reset: control reads 0, status reads 0, load reads 0xFFFFFFFF, compare reads 0, count reads 0xFFFFFFFF, and `irq` is low.
- R2: Word offsets are control 0, status 1, load 2, compare 3 and count 4. Offsets 5 to 7 read 0. Control bits 31:26 and bit 16 always read 0. Status bit 0 is the flag and the other status bits read 0. Compare is stored and read back, and it does not affect counting.
- R3: Control bits 15:4 hold a divide field D. While the timer runs, the count drops by exactly one for every D+1 pulses of the selected tick.
- R4: Control bits 25:24 select the tick source. 00 means no tick, 01 and 10 select `tick_main`, and 11 selects `tick_slow`. The unselected input has no effect.
- R5: A divided tick that arrives while the count is 0 sets the flag. With the reload bit (bit 3) set, the counter then takes the load value. With it clear, the counter takes 0xFFFFFFFF.
- R6: A write to the load register with the overwrite bit (bit 17) set also writes the new value into the counter in the same edge. With the bit clear, the counter is unchanged.
- R7: A control write that changes the enable bit (bit 0) from 0 to 1 loads the counter from the load register when the resume bit (bit 1) is 0. When the resume bit is 1, the held count is kept. The counter does not change while enable is 0 or the source is 00.
- R8: Any write to the status register clears the flag. If a zero event happens in the same cycle, the flag is set instead.
- R9: `irq` is high exactly when the flag is set and the interrupt-enable bit (bit 2) is set.
- R10: A control write with bit 16 set restores the full reset state of R1 and ignores the rest of the written word. Bit 16 is never held.
- R11: Reading any register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| tick_main | input | 1 | Main-clock tick enable pulse |
| tick_slow | input | 1 | 32 kHz tick enable pulse |
| irq | output | 1 | Level interrupt |

## Verification
The counting path is driven first on the main tick with reload and then with wrap-around. Comparing the two separates the reload branch from the all-ones branch at the same zero crossing. Pulses on the unselected tick input and a source of 00 show that only the chosen tick moves the counter. A divide of 3 shows that the prescaler waits the full D+1 pulses. An enable with resume set and one with resume clear tell keeping the held count apart from loading it. Load writes with overwrite set and clear separate an immediate replace from a register-only update. A status clear that lands in the same cycle as a zero event checks that the set takes priority.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 12;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_LOAD = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFF_CMP  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(4);

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_MAIN_A = 2'd1,
        SRC_MAIN_B = 2'd2,
        SRC_SLOW   = 2'd3
    } src_e;

    // Bit layout of the control word, lsb last
    typedef struct packed {
        src_e             src;       // 25:24
        logic [5:0]       spare;     // 23:18
        logic             ovw;       // 17
        logic             swr;       // 16
        logic [DIV_W-1:0] div;       // 15:4
        logic             rld;       // 3
        logic             ien;       // 2
        logic             resume;    // 1
        logic             en;        // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c       = ctrl_t'(w[CTRL_W-1:0]);
        c.spare = '0;
        c.swr   = 1'b0;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {{(DATA_W-CTRL_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/ptmr_tick_div.sv
module ptmr_tick_div
    import ptmr_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  src_e          src,
    input  logic [DW-1:0] div,
    input  logic          tick_main,
    input  logic          tick_slow,
    output logic          step
);
    logic [DW-1:0] pcnt;
    logic          sel;

    always_comb begin
        unique case (src)
            SRC_SLOW:   sel = tick_slow;
            SRC_MAIN_A,
            SRC_MAIN_B: sel = tick_main;
            default:    sel = 1'b0;
        endcase
    end

    assign step = run && sel && (pcnt >= div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (sel) begin
            if (pcnt >= div) pcnt <= '0;
            else             pcnt <= pcnt + 1'b1;
        end
    end

    // R3: a divided tick restarts the prescale count
    assert_div_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        step |=> (pcnt == '0));
    // R7: no tick source means no divided tick
    assert_no_src_R7: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_NONE) |-> !step);
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic         set_now,
    input  logic [W-1:0] set_val,
    input  logic         rld,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;

    assign wrap = step && !set_now && !clear && (count == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= ALL_ONES;
        end else if (set_now) begin
            count <= set_val;
        end else if (step) begin
            if (count == '0) count <= rld ? reload_val : ALL_ONES;
            else             count <= count - 1'b1;
        end
    end

    assert_dec_one_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !set_now && !clear && count != '0) |=> (count == $past(count) - 1'b1));
    assert_wrap_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap && !rld) |=> (count == ALL_ONES));
    assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap && rld) |=> (count == $past(reload_val)));
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!step && !set_now && !clear) |=> $stable(count));
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              wrap,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] load,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              set_now,
    output logic [DATA_W-1:0] set_val,
    output logic              clear
);
    localparam int SWR_BIT = 16;

    logic [DATA_W-1:0] cmp;
    logic              flag;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic              swr, en_rise, load_on_en, load_ovw;
    ctrl_t             new_ctrl;

    assign wr_ctrl  = wr_en && (addr == OFF_CTRL);
    assign wr_stat  = wr_en && (addr == OFF_STAT);
    assign wr_load  = wr_en && (addr == OFF_LOAD);
    assign wr_cmp   = wr_en && (addr == OFF_CMP);
    assign swr      = wr_ctrl && wdata[SWR_BIT];
    assign new_ctrl = word_to_ctrl(wdata);

    assign en_rise    = wr_ctrl && !swr && new_ctrl.en && !ctrl.en;
    assign load_on_en = en_rise && !new_ctrl.resume;
    assign load_ovw   = wr_load && ctrl.ovw;
    assign set_now    = load_on_en || load_ovw;
    assign set_val    = load_ovw ? wdata : load;
    assign clear      = swr;
    assign irq        = flag && ctrl.ien;

    always_ff @(posedge clk) begin
        if (rst || swr) begin
            ctrl <= '0;
            load <= '1;
            cmp  <= '0;
            flag <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl <= new_ctrl;
            if (wr_load) load <= wdata;
            if (wr_cmp)  cmp  <= wdata;
            if (wrap)         flag <= 1'b1;
            else if (wr_stat) flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            OFF_CTRL: rdata = ctrl_to_word(ctrl);
            OFF_STAT: rdata = {{(DATA_W-1){1'b0}}, flag};
            OFF_LOAD: rdata = load;
            OFF_CMP:  rdata = cmp;
            OFF_CNT:  rdata = count;
            default:  rdata = '0;
        endcase
    end

    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !wrap && !swr) |=> !flag);
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);
    assert_swr_state_R10: assert property (@(posedge clk) disable iff (rst)
        swr |=> (ctrl == '0 && load == '1 && cmp == '0 && !flag));
    assert_swr_not_held_R10: assert property (@(posedge clk) disable iff (rst)
        !ctrl.swr);
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick_main,
    input  logic              tick_slow,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] load, count, set_val;
    logic              step, wrap, set_now, clear, run;

    assign run = ctrl.en && (ctrl.src != SRC_NONE);

    ptmr_tick_div #(.DW(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(run), .src(ctrl.src), .div(ctrl.div),
        .tick_main(tick_main), .tick_slow(tick_slow), .step(step)
    );

    ptmr_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst(rst), .clear(clear), .step(step),
        .set_now(set_now), .set_val(set_val), .rld(ctrl.rld),
        .reload_val(load), .count(count), .wrap(wrap)
    );

    ptmr_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count(count), .wrap(wrap), .ctrl(ctrl), .load(load), .rdata(rdata),
        .irq(irq), .set_now(set_now), .set_val(set_val), .clear(clear)
    );

    // R6: a load write without overwrite leaves the counter alone
    assert_no_ovw_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_LOAD && !ctrl.ovw && !step) |=> $stable(count));
    // R6: a load write with overwrite lands in the counter
    assert_ovw_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_LOAD && ctrl.ovw) |=> (count == $past(wdata)));
    // R9: the line never rises without interrupt enable
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.ien |-> !irq);
endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_main = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    logic        isirq_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    ptmr_top u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                 .rdata(rdata), .tick_main(tick_main), .tick_slow(tick_slow), .irq(irq));

    // Monitor: pop expected items and compare away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                logic [31:0] e, a;
                logic        s;
                string       t;
                e = exp_q.pop_front();
                s = isirq_q.pop_front();
                t = tag_q.pop_front();
                a = s ? {31'b0, irq} : rdata;
                n_run++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [31:0] e, input string t);
        addr = a;
        exp_q.push_back(e); isirq_q.push_back(1'b0); tag_q.push_back(t);
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        exp_q.push_back({31'b0, e}); isirq_q.push_back(1'b1); tag_q.push_back(t);
        @(posedge clk); #1;
    endtask

    task automatic pulse_main(input int n);
        for (int i = 0; i < n; i++) begin
            tick_main = 1'b1; @(posedge clk); #1; tick_main = 1'b0;
        end
    endtask

    task automatic pulse_slow(input int n);
        for (int i = 0; i < n; i++) begin
            tick_slow = 1'b1; @(posedge clk); #1; tick_slow = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk(0, 32'h0, "R1 ctrl");
        chk(1, 32'h0, "R1 status");
        chk(2, 32'hFFFFFFFF, "R1 load");
        chk(3, 32'h0, "R1 compare");
        chk(4, 32'hFFFFFFFF, "R1 count");
        chk_irq(1'b0, "R1 irq");
        // R6 load without overwrite
        wr(2, 32'd5);
        chk(4, 32'hFFFFFFFF, "R6 count untouched");
        chk(2, 32'd5, "R6 load stored");
        // R7 disabled timer holds
        pulse_main(3);
        chk(4, 32'hFFFFFFFF, "R7 hold while disabled");
        // R7 enable loads count
        wr(0, 32'h0100000D);
        chk(4, 32'd5, "R7 enable loads");
        chk(0, 32'h0100000D, "R2 ctrl readback");
        // R3 counting, R4 unselected input
        pulse_main(2);
        chk(4, 32'd3, "R3 decrement");
        pulse_slow(2);
        chk(4, 32'd3, "R4 slow ignored");
        pulse_main(3);
        chk(4, 32'd0, "R3 reach zero");
        chk(1, 32'd0, "R5 no flag at zero");
        pulse_main(1);
        chk(4, 32'd5, "R5 reload");
        chk(1, 32'd1, "R5 flag set");
        chk_irq(1'b1, "R9 irq high");
        // R11 reads are side-effect free
        chk(4, 32'd5, "R11 count reread");
        chk(1, 32'd1, "R11 status reread");
        chk(5, 32'd0, "R2 unmapped offset");
        // R8 status clear
        wr(1, 32'd0);
        chk(1, 32'd0, "R8 flag cleared");
        chk_irq(1'b0, "R8 irq low");
        // R9 interrupt enable gates the line
        wr(0, 32'h01000009);
        pulse_main(6);
        chk(1, 32'd1, "R9 flag set");
        chk_irq(1'b0, "R9 irq masked");
        chk(4, 32'd5, "R5 reload again");
        wr(1, 32'd1);
        // R5 wrap to all ones
        wr(0, 32'h01000001);
        pulse_main(6);
        chk(4, 32'hFFFFFFFF, "R5 wrap to ones");
        chk(1, 32'd1, "R5 flag on wrap");
        wr(1, 32'd0);
        // R3 divide by 3
        wr(0, 32'h01000021);
        pulse_main(2);
        chk(4, 32'hFFFFFFFF, "R3 prescale wait");
        pulse_main(1);
        chk(4, 32'hFFFFFFFE, "R3 prescale step");
        // R4 source selection
        wr(0, 32'h03000001);
        pulse_slow(1);
        chk(4, 32'hFFFFFFFD, "R4 slow source");
        pulse_main(1);
        chk(4, 32'hFFFFFFFD, "R4 main ignored");
        wr(0, 32'h02000001);
        pulse_main(1);
        chk(4, 32'hFFFFFFFC, "R4 source 10 main");
        wr(0, 32'h00000001);
        pulse_main(1);
        pulse_slow(1);
        chk(4, 32'hFFFFFFFC, "R7 source off holds");
        // R7 resume vs reload on enable
        wr(0, 32'h0);
        wr(0, 32'h01000003);
        chk(4, 32'hFFFFFFFC, "R7 resume keeps");
        pulse_main(1);
        chk(4, 32'hFFFFFFFB, "R7 resume counts");
        wr(0, 32'h0);
        wr(0, 32'h01000001);
        chk(4, 32'd5, "R7 reenable loads");
        // R6 overwrite
        wr(0, 32'h01020001);
        chk(0, 32'h01020001, "R2 overwrite bit readback");
        wr(2, 32'd9);
        chk(4, 32'd9, "R6 overwrite count");
        chk(2, 32'd9, "R6 overwrite load");
        wr(2, 32'd0);
        // R8 set wins over clear
        wr_en = 1'b1; addr = 3'd1; wdata = 32'd1; tick_main = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; tick_main = 1'b0;
        chk(1, 32'd1, "R8 set beats clear");
        chk(4, 32'hFFFFFFFF, "R5 wrap after overwrite");
        // R2 upper bits masked
        wr(0, 32'hFD000005);
        chk(0, 32'h01000005, "R2 bits 31:26 zero");
        chk_irq(1'b1, "R9 irq on enable");
        wr(3, 32'h00001234);
        chk(3, 32'h00001234, "R2 compare stored");
        chk(4, 32'hFFFFFFFF, "R2 compare no effect");
        // R10 software reset
        wr(0, 32'h0101000D);
        chk(0, 32'h0, "R10 ctrl");
        chk(1, 32'h0, "R10 status");
        chk(2, 32'hFFFFFFFF, "R10 load");
        chk(3, 32'h0, "R10 compare");
        chk(4, 32'hFFFFFFFF, "R10 count");
        chk_irq(1'b0, "R10 irq");
        pulse_main(2);
        chk(4, 32'hFFFFFFFF, "R10 stays stopped");
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule